// File: doc/BRIEF.md
# Wide-Bus Bitplane Source Aligner

This block is one source channel of a rectangle copy engine. The channel is programmed in 16-bit words: a start address, a row width in words, a right shift of 0 to 15 pixels, and a 16-bit mask for the first and for the last word of the row. It fetches the row over a memory path `BUS_W` bits wide (16, 32 or 64). Every fetch address is rounded down to the bus alignment. The block works out from the address bits below that alignment how many leading words of the first fetch lie before the row. It then produces one shifted, masked bus-width word for each fetch.

The sub-word offset of the start address supplies both the extra shift and the placement of the wide masks. No added setting is needed for a wider bus, so the same programming gives the same pixels for every bus width. A mode input selects wide operation. With it low, the channel fetches one word per access and behaves as a plain 16-bit source channel. Each `start` handles one row.

Top module: `wide_src_aligner`

## Requirements
- R1: After reset `req` and `out_valid` are low.
- R2: In wide mode the first fetch address is `cfg_addr` with its low log2(BUS_W/8) bits cleared. In narrow mode it is `cfg_addr` with bit 0 cleared. Each accepted fetch (`req` and `rd_valid` high at a clock edge) advances the address by BUS_W/8 in wide mode and by 2 in narrow mode. While a fetch is not accepted, `req` and `req_addr` hold.
- R3: Let k be the count of words in the first fetch that lie before the start address (`cfg_addr` bits [log2(BUS_W/8)-1:1]). A row makes ceil((k+words)/(BUS_W/16)) fetches in wide mode and `words` fetches in narrow mode. `req` falls after the last accepted fetch.
- R4: Treat all fetched words as one bit stream, lowest address first and MSB first, after masking. Output n holds that stream shifted right by k*16+shift bits, carrying bits across fetch boundaries. Zeros enter ahead of the first fetch.
- R5: In the first fetch, words before the start address become zero and the first valid word is ANDed with `cfg_fmask`.
- R6: In the last fetch, the last valid word is ANDed with `cfg_lmask` and the words after it become zero.
- R7: When the first and last valid words are the same word, both masks apply to it.
- R8: Inside `rd_data` the lowest-addressed word sits in bits [BUS_W-1:BUS_W-16].
- R9: In narrow mode only `rd_data[15:0]` is used, the shift is `cfg_shift` alone, and `out_data` above bit 15 is zero.
- R10: `out_valid` is high exactly one cycle after each accepted fetch. `out_first` marks the output of the first fetch and `out_last` marks the output of the last fetch.
- R11: A `start` while `req` is high has no effect on the row in progress.
- R12: `rd_valid` while `req` is low produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a row with the cfg_* values |
| cfg_addr | input | ADDR_W | Byte address of the first word of the row |
| cfg_words | input | CNT_W | Row width in words, nonzero |
| cfg_shift | input | 4 | Right shift in pixels |
| cfg_fmask | input | 16 | Mask for the first word of the row |
| cfg_lmask | input | 16 | Mask for the last word of the row |
| cfg_wide | input | 1 | 1 = bus-width fetches, 0 = single-word fetches |
| req | output | 1 | Fetch pending |
| req_addr | output | ADDR_W | Aligned byte address of the pending fetch |
| rd_valid | input | 1 | Fetch data present, accepted with req |
| rd_data | input | BUS_W | Fetched data, big-endian word order |
| out_valid | output | 1 | Aligned output word valid |
| out_data | output | BUS_W | Shifted and masked output |
| out_first | output | 1 | Output belongs to the first fetch of the row |
| out_last | output | 1 | Output belongs to the last fetch of the row |

## Verification
A wrong lead-word count or a wrong last-lane index shows up as a mask error in the first or last output word. It appears on the cycle after the fetch concerned, and it also changes the number of fetches, so `req` drops early or late. A stale carry register corrupts the high bits of the very next output word. This happens first at a fetch boundary, so the tests use shifts above zero, offsets that cross fetch boundaries, and rows that span two fetches. An address step error is visible at `req_addr` on the cycle after an accepted fetch.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
   localparam int unsigned WORD_W = 16;
   localparam logic [WORD_W-1:0] WORD_ONES = '1;
endpackage

// File: rtl/wsa_seq.sv
module wsa_seq #(
   parameter int unsigned BUS_W  = 64,
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned CNT_W  = 10,
   localparam int unsigned LANES   = BUS_W / 16,
   localparam int unsigned KW      = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int unsigned LSH     = $clog2(LANES),
   localparam int unsigned BYTE_SH = $clog2(BUS_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_words,
   input  logic [3:0]        cfg_shift,
   input  logic [15:0]       cfg_fmask,
   input  logic [15:0]       cfg_lmask,
   input  logic              cfg_wide,
   input  logic              rd_valid,
   output logic              req,
   output logic [ADDR_W-1:0] req_addr,
   output logic              accept,
   output logic              rd_first,
   output logic              rd_last,
   output logic              wide_q,
   output logic [KW-1:0]     k_q,
   output logic [KW-1:0]     l_q,
   output logic [3:0]        shift_q,
   output logic [15:0]       fmask_q,
   output logic [15:0]       lmask_q
);
   logic [KW-1:0]     k_in;
   logic [KW-1:0]     l_in;
   logic [CNT_W:0]    span;
   logic [CNT_W:0]    total;
   logic [CNT_W:0]    left_q;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] step;
   logic              first_q;
   logic              go;

   generate
      if (LANES > 1) begin : g_multi
         assign k_in = cfg_wide ? cfg_addr[BYTE_SH-1:1] : '0;
         assign l_in = KW'(span - (CNT_W+1)'(1));
      end else begin : g_single
         assign k_in = '0;
         assign l_in = '0;
      end
   endgenerate

   assign span  = {1'b0, cfg_words} + (CNT_W+1)'(k_in);
   assign total = cfg_wide ? ((span + (CNT_W+1)'(LANES - 1)) >> LSH)
                           : {1'b0, cfg_words};
   assign base  = cfg_wide ? {cfg_addr[ADDR_W-1:BYTE_SH], BYTE_SH'(0)}
                           : {cfg_addr[ADDR_W-1:1], 1'b0};
   assign step  = wide_q ? ADDR_W'(BUS_W / 8) : ADDR_W'(2);
   assign go     = start && !req && (cfg_words != '0);
   assign accept = req && rd_valid;
   assign rd_first = first_q;
   assign rd_last  = (left_q == (CNT_W+1)'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req      <= 1'b0;
         req_addr <= '0;
         left_q   <= '0;
         first_q  <= 1'b0;
         wide_q   <= 1'b0;
         k_q      <= '0;
         l_q      <= '0;
         shift_q  <= '0;
         fmask_q  <= '0;
         lmask_q  <= '0;
      end else if (go) begin
         req      <= 1'b1;
         req_addr <= base;
         left_q   <= total;
         first_q  <= 1'b1;
         wide_q   <= cfg_wide;
         k_q      <= k_in;
         l_q      <= l_in;
         shift_q  <= cfg_shift;
         fmask_q  <= cfg_fmask;
         lmask_q  <= cfg_lmask;
      end else if (accept) begin
         req_addr <= req_addr + step;
         left_q   <= left_q - (CNT_W+1)'(1);
         first_q  <= 1'b0;
         if (rd_last) req <= 1'b0;
      end
   end
endmodule

// File: rtl/wsa_mask.sv
module wsa_mask #(
   parameter int unsigned BUS_W = 64,
   localparam int unsigned LANES = BUS_W / 16,
   localparam int unsigned KW    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic             wide,
   input  logic             first,
   input  logic             last,
   input  logic [KW-1:0]    k,
   input  logic [KW-1:0]    l,
   input  logic [15:0]      fmask,
   input  logic [15:0]      lmask,
   output logic [BUS_W-1:0] mask
);
   import wsa_pkg::*;

   for (genvar j = 0; j < int'(LANES); j++) begin : g_lane
      logic [15:0] fpart;
      logic [15:0] lpart;
      logic [15:0] wpart;
      logic [15:0] npart;
      always_comb begin
         if (!first)             fpart = WORD_ONES;
         else if (int'(k) > j)   fpart = '0;
         else if (int'(k) == j)  fpart = fmask;
         else                    fpart = WORD_ONES;
         if (!last)              lpart = WORD_ONES;
         else if (int'(l) > j)   lpart = WORD_ONES;
         else if (int'(l) == j)  lpart = lmask;
         else                    lpart = '0;
         wpart = fpart & lpart;
      end
      if (j == int'(LANES) - 1) begin : g_low
         assign npart = (first ? fmask : WORD_ONES) & (last ? lmask : WORD_ONES);
      end else begin : g_high
         assign npart = '0;
      end
      assign mask[BUS_W-1-16*j -: 16] = wide ? wpart : npart;
   end
endmodule

// File: rtl/wsa_shift.sv
module wsa_shift #(
   parameter int unsigned BUS_W = 64,
   localparam int unsigned LANES = BUS_W / 16,
   localparam int unsigned KW    = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int unsigned SH_W  = $clog2(BUS_W) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             first,
   input  logic             last,
   input  logic             wide,
   input  logic [KW-1:0]    k,
   input  logic [3:0]       shift,
   input  logic [BUS_W-1:0] mask,
   input  logic [BUS_W-1:0] rd_data,
   output logic             out_valid,
   output logic [BUS_W-1:0] out_data,
   output logic             out_first,
   output logic             out_last
);
   logic [BUS_W-1:0]   cur_m;
   logic [BUS_W-1:0]   carry_q;
   logic [BUS_W-1:0]   carry_eff;
   logic [2*BUS_W-1:0] op;
   logic [2*BUS_W-1:0] res;
   logic [SH_W-1:0]    eff;
   logic [BUS_W-1:0]   aligned;

   assign cur_m     = rd_data & mask;
   assign carry_eff = first ? '0 : carry_q;
   assign eff = wide ? (SH_W'({k, 4'b0000}) + SH_W'(shift)) : SH_W'(shift);
   assign op  = wide ? {carry_eff, cur_m}
                     : (2*BUS_W)'({carry_eff[15:0], cur_m[15:0]});
   assign res = op >> eff;
   assign aligned = wide ? res[BUS_W-1:0] : BUS_W'(res[15:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q   <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_first <= 1'b0;
         out_last  <= 1'b0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            carry_q   <= cur_m;
            out_data  <= aligned;
            out_first <= first;
            out_last  <= last;
         end
      end
   end
endmodule

// File: rtl/wide_src_aligner.sv
module wide_src_aligner #(
   parameter int unsigned BUS_W  = 64,
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned CNT_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_words,
   input  logic [3:0]        cfg_shift,
   input  logic [15:0]       cfg_fmask,
   input  logic [15:0]       cfg_lmask,
   input  logic              cfg_wide,
   output logic              req,
   output logic [ADDR_W-1:0] req_addr,
   input  logic              rd_valid,
   input  logic [BUS_W-1:0]  rd_data,
   output logic              out_valid,
   output logic [BUS_W-1:0]  out_data,
   output logic              out_first,
   output logic              out_last
);
   localparam int unsigned LANES = BUS_W / 16;
   localparam int unsigned KW    = (LANES > 1) ? $clog2(LANES) : 1;

   generate
      if (!(BUS_W == 16 || BUS_W == 32 || BUS_W == 64)) begin : g_bad_bus
         $error("BUS_W must be 16, 32 or 64");
      end
      if (CNT_W < 2 || ADDR_W < 8) begin : g_bad_width
         $error("CNT_W or ADDR_W too small");
      end
   endgenerate

   logic              accept;
   logic              rd_first;
   logic              rd_last;
   logic              mode_wide;
   logic [KW-1:0]     k_q;
   logic [KW-1:0]     l_q;
   logic [3:0]        shift_q;
   logic [15:0]       fmask_q;
   logic [15:0]       lmask_q;
   logic [BUS_W-1:0]  mask;

   wsa_seq #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_addr(cfg_addr), .cfg_words(cfg_words), .cfg_shift(cfg_shift),
      .cfg_fmask(cfg_fmask), .cfg_lmask(cfg_lmask), .cfg_wide(cfg_wide),
      .rd_valid(rd_valid), .req(req), .req_addr(req_addr),
      .accept(accept), .rd_first(rd_first), .rd_last(rd_last),
      .wide_q(mode_wide), .k_q(k_q), .l_q(l_q), .shift_q(shift_q),
      .fmask_q(fmask_q), .lmask_q(lmask_q)
   );

   wsa_mask #(.BUS_W(BUS_W)) u_mask (
      .wide(mode_wide), .first(rd_first), .last(rd_last),
      .k(k_q), .l(l_q), .fmask(fmask_q), .lmask(lmask_q), .mask(mask)
   );

   wsa_shift #(.BUS_W(BUS_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .accept(accept), .first(rd_first),
      .last(rd_last), .wide(mode_wide), .k(k_q), .shift(shift_q),
      .mask(mask), .rd_data(rd_data), .out_valid(out_valid),
      .out_data(out_data), .out_first(out_first), .out_last(out_last)
   );
endmodule

// File: rtl/wsa_chk.sv
module wsa_chk #(
   parameter int unsigned BUS_W  = 64,
   parameter int unsigned ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rd_valid,
   input logic              out_valid,
   input logic [BUS_W-1:0]  out_data,
   input logic              out_last,
   input logic              mode_wide
);
   localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(BUS_W / 8);

   AST_OUT_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (req && rd_valid) |=> out_valid);                                  // R10
   AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !(req && rd_valid) |=> !out_valid);                                // R12
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (req && rd_valid) |=> (!req || req_addr == $past(req_addr) +
         (mode_wide ? WSTEP : ADDR_W'(2))));                             // R2
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !rd_valid) |=> (req && $stable(req_addr)));                // R2
   AST_LAST_ENDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> !req);                                 // R3
   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !mode_wide) |-> ((out_data >> 16) == '0));          // R9
endmodule

bind wide_src_aligner wsa_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
   .rd_valid(rd_valid), .out_valid(out_valid), .out_data(out_data),
   .out_last(out_last), .mode_wide(mode_wide)
);

// File: tb/sim_wide_src_aligner.sv
module sim_wide_src_aligner;
   localparam int BUS_W = 64;
   localparam int ADDR_W = 24;
   localparam int CNT_W = 10;
   localparam int LANES = BUS_W / 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [CNT_W-1:0]  cfg_words = '0;
   logic [3:0]        cfg_shift = '0;
   logic [15:0]       cfg_fmask = '0;
   logic [15:0]       cfg_lmask = '0;
   logic              cfg_wide = 1'b0;
   logic              req;
   logic [ADDR_W-1:0] req_addr;
   logic              rd_valid = 1'b0;
   logic [BUS_W-1:0]  rd_data = '0;
   logic              out_valid;
   logic [BUS_W-1:0]  out_data;
   logic              out_first;
   logic              out_last;

   int checks = 0;
   int errors = 0;
   logic [15:0] sw [0:63];

   always #2 clk = ~clk;

   wide_src_aligner #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (.*);

   function automatic logic [15:0] memw(input logic [ADDR_W-1:0] a);
      return (a[16:1] * 16'h9E37) ^ 16'h5A3C;
   endfunction

   task automatic chk(input string req_tag, input logic [BUS_W-1:0] act,
                      input logic [BUS_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
      end
   endtask

   function automatic logic sbit(input int p);
      if (p < 0) return 1'b0;
      return sw[p / 16][15 - (p % 16)];
   endfunction

   // One row: drive fetches, check address, data, flags and fetch count.
   task automatic run_row(input string nm, input logic [ADDR_W-1:0] addr,
                          input int words, input int s, input logic [15:0] fm,
                          input logic [15:0] lm, input bit wide, input int gap,
                          input bit poke);
      int lanes = wide ? LANES : 1;
      int bytesh = wide ? 3 : 1;
      int k = wide ? int'(addr[2:1]) : 0;
      int nrd = (k + words + lanes - 1) / lanes;
      int lastw = k + words - 1;
      int eff = k * 16 + s;
      int outw = wide ? BUS_W : 16;
      logic [ADDR_W-1:0] base = (addr >> bytesh) << bytesh;
      for (int p = 0; p < nrd * lanes; p++) begin
         logic [15:0] v = memw(base + ADDR_W'(2 * p));
         if (p < k || p > lastw) v = '0;
         if (p == k) v = v & fm;
         if (p == lastw) v = v & lm;
         sw[p] = v;
      end
      @(negedge clk);
      cfg_addr = addr; cfg_words = CNT_W'(words); cfg_shift = 4'(s);
      cfg_fmask = fm; cfg_lmask = lm; cfg_wide = wide; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cfg_addr = 24'h000006; cfg_words = 10'd1; cfg_shift = 4'd9;
      cfg_fmask = 16'h0; cfg_lmask = 16'h0; cfg_wide = ~wide;
      for (int n = 0; n < nrd; n++) begin
         logic [BUS_W-1:0] exp;
         chk({nm, " R3 req during row"}, BUS_W'(req), BUS_W'(1));
         chk({nm, " R2 fetch address"}, BUS_W'(req_addr),
             BUS_W'(base + ADDR_W'(n * (wide ? BUS_W / 8 : 2))));
         for (int j = 0; j < LANES; j++)
            rd_data[BUS_W-1-16*j -: 16] = wide ? memw(req_addr + ADDR_W'(2 * j))
                                               : 16'hDEAD;
         if (!wide) rd_data[15:0] = memw(req_addr);
         rd_valid = 1'b1;
         if (poke && n == 0) start = 1'b1;
         @(negedge clk);
         rd_valid = 1'b0; start = 1'b0;
         exp = '0;
         for (int i = 0; i < outw; i++)
            exp[outw - 1 - i] = sbit(n * outw - eff + i);
         chk({nm, " R10 out_valid"}, BUS_W'(out_valid), BUS_W'(1));
         chk({nm, " R4 R5 R6 R8 R9 out_data"}, out_data, exp);
         chk({nm, " R10 out_first"}, BUS_W'(out_first), BUS_W'(n == 0));
         chk({nm, " R10 out_last"}, BUS_W'(out_last), BUS_W'(n == nrd - 1));
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk({nm, " R10 idle no output"}, BUS_W'(out_valid), BUS_W'(0));
         end
      end
      chk({nm, " R3 req falls after last fetch"}, BUS_W'(req), BUS_W'(0));
   endtask

   task automatic t_reset;
      chk("R1 req after reset", BUS_W'(req), BUS_W'(0));
      chk("R1 out_valid after reset", BUS_W'(out_valid), BUS_W'(0));
   endtask

   task automatic t_idle_valid;
      @(negedge clk);
      rd_valid = 1'b1; rd_data = '1;
      @(negedge clk);
      rd_valid = 1'b0;
      chk("R12 rd_valid while idle", BUS_W'(out_valid), BUS_W'(0));
      chk("R12 req stays low", BUS_W'(req), BUS_W'(0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_valid();
      // aligned, two fetches, no shift: R2 R3 R4 R8
      run_row("aligned", 24'h01DED0, 8, 0, 16'hFFFF, 16'hFFFF, 1'b1, 0, 1'b0);
      // two lead words, 5-pixel shift (37 bits), masks: R4 R5 R6
      run_row("offset2", 24'h01DED4, 3, 5, 16'h0FFF, 16'hFFF0, 1'b1, 0, 1'b0);
      // first and last valid words in one fetch: R7
      run_row("single", 24'h01DED2, 2, 3, 16'h7FFE, 16'hF00F, 1'b1, 0, 1'b0);
      // one word total, first==last word: R7
      run_row("oneword", 24'h01DED6, 1, 15, 16'h3FFC, 16'hFF00, 1'b1, 0, 1'b0);
      // last fetch ends mid-block, trailing words ignored: R6
      run_row("trail", 24'h000102, 6, 9, 16'hFFFF, 16'hC000, 1'b1, 1, 1'b0);
      // narrow mode: R9
      run_row("narrow", 24'h01DED2, 3, 7, 16'h00FF, 16'hFF80, 1'b0, 0, 1'b0);
      // start while busy ignored, gaps between fetches: R11 R10
      run_row("poke", 24'h002346, 9, 12, 16'h1FFF, 16'hFFF8, 1'b1, 2, 1'b1);
      run_row("npoke", 24'h00400A, 2, 1, 16'hF0F0, 16'h0F0F, 1'b0, 1, 1'b1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule